// File: doc/BRIEF.md
# Sampling Converter Serial Output Sequencer

This block models the digital output side of a 12-bit sampling converter. A host lowers an active-low chip select and then toggles a serial clock. On the second serial clock fall after the select goes low, the block takes the sample word from a stand-in data source and pulses a strobe. It then turns its output enable on and drives one null bit. The word follows, most significant bit first, with one bit per serial clock fall. If the select stays low, the block sends the word a second time with the least significant bit first. This repeat starts at bit 1, because bit 0 was the last bit of the first pass. After the repeat the output stops.

The block also reports two power flags. The analog flag goes high once the conversion is finished, even while the select is still low. The full flag shows that the select is high and the block is idle. Raising the select at any point stops the output and turns both flags on. The serial clock and the select are treated as plain data inputs, sampled by a fast system clock. A serial clock fall is detected in the system cycle where a sampled high is followed by a sampled low. The word is two's complement: 0x7FF is the largest positive code, 0x800 the most negative, 0x000 zero, and 0xFFF one step below zero.

Top module: `sar_serial_seq`

## Requirements
- R1: After reset, `dout_en`, `dout` and `sample_strobe` are 0, and `analog_off` and `full_off` are 1.
- R2: A frame starts only when `cs_n` goes from high to low. If `cs_n` is already low when reset ends, no frame starts, and serial clock falls leave every output in the R1 state. While `cs_n` is high, serial clock falls have no effect.
- R3: `sample_strobe` is high for exactly one system cycle per frame, in the cycle after the 2nd serial clock fall is detected. The word is captured at that point, and later changes on `sample_word` do not change the bits sent in that frame.
- R4: From the 2nd fall, `dout_en` is 1 and `dout` carries a null bit of 0.
- R5: Falls 3 through 14 put word bits 11 down to 0 on `dout`, one bit per fall. Each bit appears in the system cycle after its fall is detected.
- R6: With `cs_n` still low, falls 15 through 25 put word bits 1 up to 11 on `dout`. From the 26th fall on, `dout_en` is 0. Any number of further falls leaves it at 0; the fall counter saturates and does not wrap.
- R7: While `cs_n` is high, `dout_en` and `dout` are 0 and both power flags are 1. This follows `cs_n` in the same cycle, with no register in the path. Raising `cs_n` before the 15th fall therefore ends the frame after bit 0, with no repeat.
- R8: Inside a frame with `cs_n` low, `full_off` is 0. `analog_off` is 0 until the 14th fall and 1 from the 14th fall on.
- R9: `dout` is 0 whenever `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every input |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select; its falling edge opens a frame |
| sclk | input | 1 | Serial clock from the host; its falls advance the frame |
| sample_word | input | 12 | Two's complement sample from the data source |
| dout | output | 1 | Serial data bit |
| dout_en | output | 1 | High while the output driver would be active |
| sample_strobe | output | 1 | One-cycle pulse when the word is taken |
| analog_off | output | 1 | Analog section powered down |
| full_off | output | 1 | Whole block powered down (select high or idle) |

## Verification
The block's only state is the fall count, the frame-active flag and the captured word, so a wrong fall count shows up at the port as a bit slip. A count that is one too high or too low puts the wrong bit on `dout` one system cycle after the next serial clock fall, and it moves the edge of `dout_en` and of `analog_off` by one fall. A frame-active flag that is wrong, or a counter that wraps, shows as `dout_en` turning on again after the 25th fall or without a select fall. A word captured at the wrong moment shows as bits from the changed input within the first data bit after the strobe.

// File: rtl/sar_serial_pkg.sv
// Package: constants and helpers shared by the serial output sequencer.
// Positions are counted in serial clock falls since the select fell.
package sar_serial_pkg;

    // Fall at which the word is taken and the null bit is driven.
    localparam int unsigned NULL_FALL = 2;

    // Fall that carries the least significant bit of the first pass.
    function automatic int unsigned lsb_fall(input int unsigned width);
        return NULL_FALL + width;
    endfunction

    // Last fall that still drives data (end of the reversed pass).
    function automatic int unsigned last_fall(input int unsigned width);
        return 2 * width + 1;
    endfunction

    // Saturation value of the fall counter: one past the last data fall.
    function automatic int unsigned sat_fall(input int unsigned width);
        return 2 * width + 2;
    endfunction

    // Counter width that holds the saturation value.
    function automatic int unsigned cnt_bits(input int unsigned width);
        return $clog2(2 * width + 3);
    endfunction

endpackage

// File: rtl/sar_serial_edge.sv
// Module: edge detector for the serial clock and the chip select.
// Assumes both inputs are already synchronous to clk. The reset value of the
// select history is 0, so a select that is low when reset ends is not taken
// as a falling edge.
module sar_serial_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    output logic sclk_fall,
    output logic cs_fall
);

    logic sclk_q;
    logic cs_q;

    // Keep last cycle's samples of both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b0;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
        end
    end

    // A fall is a sampled high followed by a present low.
    always_comb begin
        sclk_fall = sclk_q & ~sclk;
        cs_fall   = cs_q & ~cs_n;
    end

endmodule

// File: rtl/sar_serial_frame.sv
// Module: frame tracker. It holds the frame-active flag and a saturating
// count of serial clock falls since the select fell, and it marks the capture
// fall. Assumes that a select fall and a serial clock fall do not land in the
// same system cycle.
module sar_serial_frame
    import sar_serial_pkg::*;
#(
    parameter int unsigned WIDTH = 12,
    localparam int unsigned CNT_W = cnt_bits(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             cs_fall,
    input  logic             sclk_fall,
    output logic             active,
    output logic [CNT_W-1:0] cnt,
    output logic             capture,
    output logic             strobe
);

    localparam logic [CNT_W-1:0] SAT_C     = CNT_W'(sat_fall(WIDTH));
    localparam logic [CNT_W-1:0] PRE_NULL  = CNT_W'(NULL_FALL - 1);

    // The fall that reaches the null position captures the word.
    always_comb begin
        capture = active & ~cs_n & sclk_fall & (cnt == PRE_NULL);
    end

    // Open on a select fall, close on select high, count falls up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= capture;
            if (cs_n) begin
                active <= 1'b0;
                cnt    <= '0;
            end else if (cs_fall) begin
                active <= 1'b1;
                cnt    <= '0;
            end else if (active && sclk_fall && cnt != SAT_C) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sar_serial_out.sv
// Module: output stage. It keeps the captured word and decodes the fall count
// into the enable, the serial bit and the two power flags. The enable and the
// flags are gated directly by the select, so raising it acts in the same cycle.
module sar_serial_out
    import sar_serial_pkg::*;
#(
    parameter int unsigned WIDTH = 12,
    localparam int unsigned CNT_W = cnt_bits(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             active,
    input  logic [CNT_W-1:0] cnt,
    input  logic             capture,
    input  logic [WIDTH-1:0] sample_word,
    output logic             dout,
    output logic             dout_en,
    output logic             analog_off,
    output logic             full_off
);

    localparam logic [CNT_W-1:0] FIRST_C = CNT_W'(NULL_FALL);
    localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(last_fall(WIDTH));
    localparam logic [CNT_W-1:0] DONE_C  = CNT_W'(lsb_fall(WIDTH));

    logic [WIDTH-1:0] word_q;
    logic             bit_sel;

    // Hold the word taken at the capture fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (capture) begin
            word_q <= sample_word;
        end
    end

    // Pick the bit for the current fall: forward pass, then reversed pass without bit 0.
    always_comb begin
        bit_sel = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            if (cnt == CNT_W'(lsb_fall(WIDTH) - i)) bit_sel = word_q[i];
            if (i > 0 && cnt == CNT_W'(lsb_fall(WIDTH) + i)) bit_sel = word_q[i];
        end
    end

    // Power flags and driver enable.
    always_comb begin
        full_off   = cs_n | ~active;
        analog_off = full_off | (cnt >= DONE_C);
        dout_en    = ~full_off & (cnt >= FIRST_C) & (cnt <= LAST_C);
        dout       = dout_en & bit_sel;
    end

endmodule

// File: rtl/sar_serial_seq.sv
// Module: top of the serial output sequencer. It joins the edge detector, the
// frame tracker and the output stage. Assumes sclk and cs_n are synchronous
// to clk and that each sclk level lasts at least two clk cycles.
module sar_serial_seq
    import sar_serial_pkg::*;
#(
    parameter int unsigned WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic [WIDTH-1:0] sample_word,
    output logic             dout,
    output logic             dout_en,
    output logic             sample_strobe,
    output logic             analog_off,
    output logic             full_off
);

    localparam int unsigned CNT_W = cnt_bits(WIDTH);

    logic             sclk_fall;
    logic             cs_fall;
    logic             active;
    logic [CNT_W-1:0] cnt;
    logic             capture;

    sar_serial_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .sclk_fall (sclk_fall),
        .cs_fall   (cs_fall)
    );

    sar_serial_frame #(.WIDTH(WIDTH)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .cs_fall   (cs_fall),
        .sclk_fall (sclk_fall),
        .active    (active),
        .cnt       (cnt),
        .capture   (capture),
        .strobe    (sample_strobe)
    );

    sar_serial_out #(.WIDTH(WIDTH)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .active      (active),
        .cnt         (cnt),
        .capture     (capture),
        .sample_word (sample_word),
        .dout        (dout),
        .dout_en     (dout_en),
        .analog_off  (analog_off),
        .full_off    (full_off)
    );

endmodule

// File: rtl/sar_serial_seq_chk.sv
// Module: port-level property checker for the sequencer, bound to the top.
module sar_serial_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic dout,
    input logic dout_en,
    input logic sample_strobe,
    input logic analog_off,
    input logic full_off
);

    // R7: a high select silences the output and powers everything down.
    p_deselect_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!dout_en && full_off && analog_off));

    // R9: no data without the enable.
    p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> !dout);

    // R3: the strobe lasts a single cycle.
    p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |=> !sample_strobe);

    // R4: the enable only turns on together with the capture strobe.
    p_enable_with_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_en) |-> sample_strobe);

    // R8: full power-down implies the analog section is off.
    p_full_implies_analog_r8: assert property (@(posedge clk) disable iff (!rst_n)
        full_off |-> analog_off);

    // R5: an enabled data bit changes only one cycle after a serial clock fall.
    p_bit_moves_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && $past(dout_en) && !$stable(dout)) |-> ($past(sclk, 2) && !$past(sclk)));

endmodule

bind sar_serial_seq sar_serial_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs_n          (cs_n),
    .sclk          (sclk),
    .dout          (dout),
    .dout_en       (dout_en),
    .sample_strobe (sample_strobe),
    .analog_off    (analog_off),
    .full_off      (full_off)
);

// File: tb/sar_serial_seq_test.sv
// Directed bench for the serial output sequencer.
module sar_serial_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic [11:0] sample_word = '0;
    logic        dout;
    logic        dout_en;
    logic        sample_strobe;
    logic        analog_off;
    logic        full_off;

    int checks = 0;
    int fails  = 0;
    int strobes = 0;

    always #4 clk = ~clk;

    sar_serial_seq #(.WIDTH(12)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_n          (cs_n),
        .sclk          (sclk),
        .sample_word   (sample_word),
        .dout          (dout),
        .dout_en       (dout_en),
        .sample_strobe (sample_strobe),
        .analog_off    (analog_off),
        .full_off      (full_off)
    );

    // Count strobe cycles away from the active edge.
    always @(negedge clk) if (rst_n && sample_strobe) strobes++;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One serial clock period ending on a fall; outputs settle before return.
    task automatic sfall();
        sclk = 1'b1;
        tick(4);
        sclk = 1'b0;
        tick(4);
    endtask

    function automatic bit exp_en(input int k);
        return (k >= 2 && k <= 25);
    endfunction

    function automatic bit exp_bit(input int k, input logic [11:0] w);
        if (k >= 3 && k <= 14) return w[14 - k];
        if (k >= 15 && k <= 25) return w[k - 14];
        return 1'b0;
    endfunction

    task automatic open_frame(input logic [11:0] w);
        sample_word = w;
        cs_n = 1'b1;
        tick(4);
        cs_n = 1'b0;
        tick(4);
        strobes = 0;
    endtask

    // Outputs after fall k of a frame with the select still low.
    task automatic check_fall(input int k, input logic [11:0] w);
        string tag;
        tag = (k == 2) ? "R4" : (k <= 14) ? "R5" : "R6";
        chk(dout_en == exp_en(k), tag, $sformatf("enable at fall %0d", k), dout_en, exp_en(k));
        chk(dout == exp_bit(k, w), tag, $sformatf("bit at fall %0d", k), dout, exp_bit(k, w));
        chk(analog_off == (k >= 14), "R8", $sformatf("analog flag at fall %0d", k),
            analog_off, (k >= 14));
        chk(full_off == 1'b0, "R8", $sformatf("full flag at fall %0d", k), full_off, 0);
    endtask

    task automatic t_reset();
        cs_n = 1'b1;
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        chk(dout_en == 0, "R1", "enable after reset", dout_en, 0);
        chk(dout == 0, "R1", "data after reset", dout, 0);
        chk(sample_strobe == 0, "R1", "strobe after reset", sample_strobe, 0);
        chk(analog_off == 1, "R1", "analog flag after reset", analog_off, 1);
        chk(full_off == 1, "R1", "full flag after reset", full_off, 1);
    endtask

    // Whole frame with repeat, a word change after capture and surplus falls.
    task automatic t_full(input logic [11:0] w);
        open_frame(w);
        for (int k = 1; k <= 40; k++) begin
            sfall();
            if (k == 2) sample_word = ~w;
            check_fall(k, w);
        end
        chk(strobes == 1, "R3", "strobe cycles in frame", strobes, 1);
        cs_n = 1'b1;
        tick(4);
    endtask

    // Select raised before fall 15: no repeat (R7).
    task automatic t_early(input logic [11:0] w);
        open_frame(w);
        for (int k = 1; k <= 14; k++) begin
            sfall();
            check_fall(k, w);
        end
        sclk = 1'b1;
        tick(2);
        cs_n = 1'b1;
        #1;
        chk(dout_en == 0, "R7", "enable right after select rise", dout_en, 0);
        chk(full_off == 1, "R7", "full flag right after select rise", full_off, 1);
        tick(2);
        sclk = 1'b0;
        tick(4);
        for (int k = 16; k <= 20; k++) begin
            sfall();
            chk(dout_en == 0, "R7", $sformatf("no repeat at fall %0d", k), dout_en, 0);
            chk(dout == 0, "R9", $sformatf("quiet data at fall %0d", k), dout, 0);
        end
    endtask

    // Abort in mid-word; further falls with the select high do nothing.
    task automatic t_abort(input logic [11:0] w);
        open_frame(w);
        for (int k = 1; k <= 6; k++) begin
            sfall();
            check_fall(k, w);
        end
        cs_n = 1'b1;
        #1;
        chk(dout_en == 0, "R7", "enable at abort", dout_en, 0);
        chk(analog_off == 1, "R7", "analog flag at abort", analog_off, 1);
        chk(dout == 0, "R9", "data at abort", dout, 0);
        strobes = 0;
        for (int k = 1; k <= 4; k++) begin
            sfall();
            chk(dout_en == 0, "R2", "falls while deselected", dout_en, 0);
        end
        chk(strobes == 0, "R2", "no strobe while deselected", strobes, 0);
    endtask

    // Select already low at reset release: no frame.
    task automatic t_low_at_reset();
        cs_n = 1'b0;
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        strobes = 0;
        for (int k = 1; k <= 5; k++) begin
            sfall();
            chk(dout_en == 0, "R2", $sformatf("enable without select fall, fall %0d", k), dout_en, 0);
            chk(full_off == 1, "R2", "full flag without select fall", full_off, 1);
        end
        chk(strobes == 0, "R2", "strobe without select fall", strobes, 0);
        cs_n = 1'b1;
        tick(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_full(12'h7FF);
        t_full(12'h800);
        t_full(12'hA5C);
        t_early(12'h3C6);
        t_abort(12'hFFF);
        t_full(12'h001);
        t_low_at_reset();
        t_full(12'h000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule